// File: doc/BRIEF.md
# Bidirectional Latched/Registered Bus Transceiver

This block carries data in both directions between two ports of equal width, A and B. Each direction owns one storage element and four controls: an active-low output enable, a latch enable, a bus-side capture clock and an active-low clock enable. With the latch enable high the direction is transparent. With it low, the stored word is held. A low-to-high transition of the capture clock, when the clock enable allows it, loads the current input word.

The whole block runs on one fast system clock. The capture-clock inputs are treated as asynchronous levels. Each one passes through a two-flop synchronizer and is compared with its previous sampled level, which yields a single-cycle capture strobe. In transparent mode the storage element is rewritten on every system clock, so lowering the latch enable freezes the last word that passed through.

Neither port drives a tri-state internally. Each port presents a data word and an active-high drive enable, and the enclosing level builds the bidirectional pads from these.

Top module: `ubt_top`

## Requirements
- R1: When a direction's latch enable is high, its destination data output equals its source input in the same cycle.
- R2: While the latch enable is high the storage element is rewritten on every system clock edge. After the latch enable falls, the output keeps the last word that passed through, even if the input changes.
- R3: With the latch enable low and no capture-clock rising edge, the destination output does not change when the source input changes.
- R4: With the latch enable low and the active-low clock enable low, a rising capture-clock level loads the source word. The word appears on the output after the third rising system-clock edge that samples the capture clock high. Each detected edge gives a strobe exactly one cycle long.
- R5: With the clock enable high, capture-clock rising edges leave the stored word unchanged.
- R6: A falling capture-clock edge never loads data.
- R7: A port's drive enable is the inverse of that direction's active-low output enable. The drive enable has no effect on the data output word.
- R8: The B-to-A direction behaves like the A-to-B direction, using its own four controls. Activity in one direction leaves the other direction's output unchanged.
- R9: A synchronous active-high reset clears both storage elements to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| aIn | input | WIDTH | Word received on port A |
| bIn | input | WIDTH | Word received on port B |
| abOutEnN | input | 1 | Active-low output enable, A to B |
| abLatchEn | input | 1 | Latch enable, A to B (high = transparent) |
| abBusClk | input | 1 | Capture clock, A to B (asynchronous level) |
| abClkEnN | input | 1 | Active-low capture clock enable, A to B |
| baOutEnN | input | 1 | Active-low output enable, B to A |
| baLatchEn | input | 1 | Latch enable, B to A |
| baBusClk | input | 1 | Capture clock, B to A |
| baClkEnN | input | 1 | Active-low capture clock enable, B to A |
| aOut | output | WIDTH | Word to drive on port A |
| aDrive | output | 1 | Drive enable for port A pads |
| bOut | output | WIDTH | Word to drive on port B |
| bDrive | output | 1 | Drive enable for port B pads |

## Verification
The transparent result and the drive enables are combinational, so the bench checks them one clock edge after it applies the stimulus. A transparent rewrite of the storage element or a reset is due after one edge. A capture is due after the third edge that samples the raised capture clock. The bench holds each raised or lowered capture clock for four system edges before it samples, and keeps the data and clock enable steady over that window. All inputs change on the falling edge, and outputs are read one nanosecond after a rising edge, so no result depends on the order of processes at an edge.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  typedef struct packed {
    logic passThru;
    logic capture;
    logic driveEn;
  } ubtStrobes_t;

  localparam int DIR_COUNT = 2;
endpackage

// File: rtl/ubt_ctrl.sv
module ubt_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 busClk,
  input  logic                 clkEnN,
  input  logic                 latchEn,
  input  logic                 outEnN,
  output ubt_pkg::ubtStrobes_t strobes
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] syncQ;
  logic         prevQ;
  logic         rise;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) begin
          syncQ <= '0;
          prevQ <= 1'b0;
        end else begin
          syncQ <= {syncQ[MSB-1:0], busClk};
          prevQ <= syncQ[MSB];
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          syncQ <= '0;
          prevQ <= 1'b0;
        end else begin
          syncQ <= busClk;
          prevQ <= syncQ[MSB];
        end
      end
    end
  endgenerate

  assign rise = syncQ[MSB] & ~prevQ;

  always_comb begin
    strobes.passThru = latchEn;
    strobes.capture  = rise & ~clkEnN & ~latchEn;
    strobes.driveEn  = ~outEnN;
  end

  // R4: an edge yields a strobe of exactly one cycle
  p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/ubt_path.sv
module ubt_path #(
  parameter int WIDTH = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [WIDTH-1:0]     srcData,
  input  ubt_pkg::ubtStrobes_t strobes,
  output logic [WIDTH-1:0]     dstData,
  output logic                 dstDrive
);
  logic [WIDTH-1:0] store;

  always_ff @(posedge clk) begin
    if (rst)                   store <= '0;
    else if (strobes.passThru) store <= srcData;
    else if (strobes.capture)  store <= srcData;
  end

  assign dstData  = strobes.passThru ? srcData : store;
  assign dstDrive = strobes.driveEn;

  // R2: transparent mode rewrites storage each cycle
  p_transp_track_r2: assert property (@(posedge clk) disable iff (rst)
    strobes.passThru |=> store == $past(srcData));
  // R3: no strobe and latch closed means hold
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!strobes.passThru && !strobes.capture) |=> $stable(store));
  // R4: a strobe loads the source word
  p_capture_r4: assert property (@(posedge clk) disable iff (rst)
    (!strobes.passThru && strobes.capture) |=> store == $past(srcData));
  // R9: reset clears storage
  p_reset_r9: assert property (@(posedge clk)
    rst |=> store == '0);
endmodule

// File: rtl/ubt_top.sv
module ubt_top #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             abOutEnN,
  input  logic             abLatchEn,
  input  logic             abBusClk,
  input  logic             abClkEnN,
  input  logic             baOutEnN,
  input  logic             baLatchEn,
  input  logic             baBusClk,
  input  logic             baClkEnN,
  output logic [WIDTH-1:0] aOut,
  output logic             aDrive,
  output logic [WIDTH-1:0] bOut,
  output logic             bDrive
);
  import ubt_pkg::*;

  logic [WIDTH-1:0] srcArr [DIR_COUNT];
  logic [WIDTH-1:0] dstArr [DIR_COUNT];
  logic [DIR_COUNT-1:0] busClkArr, clkEnNArr, latchEnArr, outEnNArr, driveArr;

  // index 0: A to B, index 1: B to A
  assign srcArr[0]  = aIn;
  assign srcArr[1]  = bIn;
  assign busClkArr  = {baBusClk, abBusClk};
  assign clkEnNArr  = {baClkEnN, abClkEnN};
  assign latchEnArr = {baLatchEn, abLatchEn};
  assign outEnNArr  = {baOutEnN, abOutEnN};

  generate
    for (genvar d = 0; d < DIR_COUNT; d++) begin : g_dir
      ubtStrobes_t strobes;

      ubt_ctrl #(.SYNC_STAGES(2)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .busClk  (busClkArr[d]),
        .clkEnN  (clkEnNArr[d]),
        .latchEn (latchEnArr[d]),
        .outEnN  (outEnNArr[d]),
        .strobes (strobes)
      );

      ubt_path #(.WIDTH(WIDTH)) u_path (
        .clk      (clk),
        .rst      (rst),
        .srcData  (srcArr[d]),
        .strobes  (strobes),
        .dstData  (dstArr[d]),
        .dstDrive (driveArr[d])
      );
    end
  endgenerate

  assign bOut   = dstArr[0];
  assign bDrive = driveArr[0];
  assign aOut   = dstArr[1];
  assign aDrive = driveArr[1];

  // R7: each drive enable mirrors its output enable
  p_drive_r7: assert property (@(posedge clk) disable iff (rst)
    (bDrive != abOutEnN) && (aDrive != baOutEnN));
endmodule

// File: tb/ubt_top_tb.sv
module ubt_top_tb;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] aIn, bIn, aOut, bOut;
  logic abOutEnN, abLatchEn, abBusClk, abClkEnN;
  logic baOutEnN, baLatchEn, baBusClk, baClkEnN;
  logic aDrive, bDrive;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  ubt_top #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .aIn(aIn), .bIn(bIn),
    .abOutEnN(abOutEnN), .abLatchEn(abLatchEn), .abBusClk(abBusClk), .abClkEnN(abClkEnN),
    .baOutEnN(baOutEnN), .baLatchEn(baLatchEn), .baBusClk(baBusClk), .baClkEnN(baClkEnN),
    .aOut(aOut), .aDrive(aDrive), .bOut(bOut), .bDrive(bDrive)
  );

  // vector: {req, latchEn, outEnN, clkEnN, pulse, aIn, expB, expDrive}
  typedef struct packed {
    logic [7:0]   req;
    logic         le;
    logic         oeN;
    logic         ceN;
    logic         pulse;
    logic [W-1:0] din;
    logic [W-1:0] expB;
    logic         expDrv;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'd1, 1'b1, 1'b0, 1'b1, 1'b0, 18'h12345, 18'h12345, 1'b1}, // R1
    '{8'd1, 1'b1, 1'b0, 1'b1, 1'b0, 18'h00ABC, 18'h00ABC, 1'b1}, // R1
    '{8'd2, 1'b0, 1'b0, 1'b1, 1'b0, 18'h3FFFF, 18'h00ABC, 1'b1}, // R2
    '{8'd3, 1'b0, 1'b0, 1'b1, 1'b0, 18'h15555, 18'h00ABC, 1'b1}, // R3
    '{8'd4, 1'b0, 1'b0, 1'b0, 1'b1, 18'h15555, 18'h15555, 1'b1}, // R4
    '{8'd5, 1'b0, 1'b0, 1'b1, 1'b1, 18'h2AAAA, 18'h15555, 1'b1}, // R5
    '{8'd7, 1'b0, 1'b1, 1'b1, 1'b0, 18'h2AAAA, 18'h15555, 1'b0}, // R7
    '{8'd7, 1'b1, 1'b1, 1'b1, 1'b0, 18'h2AAAA, 18'h2AAAA, 1'b0}, // R7
    '{8'd4, 1'b0, 1'b0, 1'b0, 1'b1, 18'h00001, 18'h00001, 1'b1}  // R4
  };

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulseAb();
    @(negedge clk) abBusClk = 1'b1;
    settle(4);
    @(negedge clk) abBusClk = 1'b0;
    settle(4);
  endtask

  task automatic pulseBa();
    @(negedge clk) baBusClk = 1'b1;
    settle(4);
    @(negedge clk) baBusClk = 1'b0;
    settle(4);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    aIn = '0; bIn = '0;
    abOutEnN = 1'b1; abLatchEn = 1'b0; abBusClk = 1'b0; abClkEnN = 1'b1;
    baOutEnN = 1'b1; baLatchEn = 1'b0; baBusClk = 1'b0; baClkEnN = 1'b1;
    settle(3);
    check("R9 reset bOut", bOut, '0);
    check("R9 reset aOut", aOut, '0);
    check("R7 reset bDrive", W'(bDrive), W'(1'b0));
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      abLatchEn = VECS[i].le;
      abOutEnN  = VECS[i].oeN;
      abClkEnN  = VECS[i].ceN;
      aIn       = VECS[i].din;
      if (VECS[i].pulse) pulseAb();
      else settle(1);
      check($sformatf("R%0d vec%0d bOut", VECS[i].req, i), bOut, VECS[i].expB);
      check($sformatf("R%0d vec%0d bDrive", VECS[i].req, i), W'(bDrive), W'(VECS[i].expDrv));
    end

    // R6: falling capture-clock edge does not load
    @(negedge clk) begin abLatchEn = 1'b0; abClkEnN = 1'b0; aIn = 18'h0F0F0; end
    @(negedge clk) abBusClk = 1'b1;
    settle(4);
    check("R6 load on rise", bOut, 18'h0F0F0);
    @(negedge clk) aIn = 18'h30303;
    @(negedge clk) abBusClk = 1'b0;
    settle(4);
    check("R6 no load on fall", bOut, 18'h0F0F0);

    // R8: B to A direction, independent of A to B
    @(negedge clk) begin baOutEnN = 1'b0; baLatchEn = 1'b1; bIn = 18'h2468A; end
    settle(1);
    check("R8 transparent aOut", aOut, 18'h2468A);
    check("R8 aDrive", W'(aDrive), W'(1'b1));
    check("R8 bOut untouched", bOut, 18'h0F0F0);
    @(negedge clk) begin baLatchEn = 1'b0; bIn = 18'h13579; end
    settle(1);
    check("R8 hold aOut", aOut, 18'h2468A);
    @(negedge clk) baClkEnN = 1'b1;
    pulseBa();
    check("R8 gated aOut", aOut, 18'h2468A);
    @(negedge clk) baClkEnN = 1'b0;
    pulseBa();
    check("R8 capture aOut", aOut, 18'h13579);
    check("R8 bOut still", bOut, 18'h0F0F0);

    // R9: synchronous reset clears both storage elements
    @(negedge clk) rst = 1'b1;
    settle(1);
    check("R9 reset bOut", bOut, '0);
    check("R9 reset aOut", aOut, '0);
    @(negedge clk) rst = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule